// File: doc/BRIEF.md
# Register-Mapped Data EEPROM Controller

This block gives a CPU access to a small byte-wide nonvolatile data store. The store is not mapped into the CPU's address space. Software reaches it through four special registers instead: a data register, an address register, a control/status register and a key register. The key register has no storage. A read takes one clock. A write runs as a timed cycle: it erases the addressed location to 0xFF at the start, and it stores the new byte when the internal timer expires.

Three things guard each write: a write-enable bit, a two-byte unlock sequence on the key register, and a target-select field that must point at the data array. Each start bit is set by software and cleared by hardware. A finished write raises an interrupt flag that stays set until software clears it. A synchronous soft reset that lands during a write aborts the write and leaves the error flag set. A power-on reset clears everything, the error flag included.

The register port is a plain single-cycle strobe bus with no back-pressure, because no data stream passes through the block. A write strobe takes effect at the next rising clock edge. Read data is combinational from the current register select. A read strobe has no side effect, except that it counts as a register access for the unlock rule.

Top module: `eeprom_regctl`

## Requirements
- R1: After power-on reset the data, address and control registers read 0x00 and `irq` is 0.
- R2: Register select 0 is data, 1 is address, 2 is control and 3 is key. Data and address registers read back the last value written. The key register always reads 0x00, whatever was written to it.
- R3: In the control register, bit 7 selects program memory, bit 6 selects configuration, bit 4 is the write-done flag, bit 3 is the error flag, bit 2 is write enable, bit 1 is write-start and bit 0 is read-start. Bit 5 reads 0. Writing control with bit 0 = 1, bits 7:6 = 00 and no write in progress makes bit 0 read 1 for one clock. The data register then holds the array byte at address[6:0], so addresses 0x80 to 0xFF alias onto 0x00 to 0x7F.
- R4: A read-start request is ignored when bit 7 or bit 6 of the written value is 1: bit 0 stays 0 and the data register is unchanged.
- R5: A write starts only if the control write with bit 1 = 1 immediately follows a key write of 0x55 and then a key write of 0xAA. Any other register access in between, read or write, cancels the unlock. A start attempt without a valid unlock does not write the array and sets bit 3.
- R6: A start attempt made while the stored write-enable bit is 0 does not write the array and sets bit 3.
- R7: An accepted write keeps bit 1 at 1 for exactly WR_CYCLES clocks, and writing 0 to bit 1 does not clear it. Bit 1 then clears, and the byte stored at address[6:0] is the data register value at the time of the start.
- R8: When a write completes, bit 4 and `irq` become 1. They stay 1 when software writes control with bit 4 = 1, and clear when it writes bit 4 = 0.
- R9: While a write is in progress, read-start and write-start requests are ignored and do not set bit 3.
- R10: A soft reset during a write aborts it. Afterwards control reads 0x08, `irq` is 0, the write never completes, and the location reads 0xFF.
- R11: A write-start attempt with bit 7 or bit 6 set does not write the array and sets bit 3.
- R12: Software can clear bit 3 only by writing it as 0, and writing it as 1 keeps its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| srst | input | 1 | Synchronous soft reset; aborts a write and keeps the error flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access for unlock) |
| reg_sel | input | 2 | Register select: 0 data, 1 address, 2 control, 3 key |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Write-done interrupt flag |

## Verification
On every cycle, assertions check the following. A write cycle begins only right after the unlock was armed and write enable was set. The software-visible start bit always matches the internal timer's busy state, and the timer count stays within its window. A read-start pulse lasts exactly one clock and never appears during a write. The done flag rises only on timer expiry, and an aborting soft reset always leaves the error flag set. Other behaviour can only be shown by the bench's scenarios: the exact length of the write cycle, what the array holds after a write or an abort, address aliasing, a broken unlock and the rejected targets that leave memory untouched, and the key register reading zero.

// File: rtl/eeprom_regctl_pkg.sv
package eeprom_regctl_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  localparam int B_RD  = 0;
  localparam int B_WR  = 1;
  localparam int B_WEN = 2;
  localparam int B_ERR = 3;
  localparam int B_IRQ = 4;
  localparam int B_CFG = 6;
  localparam int B_MEM = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] ERASED     = 8'hFF;
endpackage

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 128,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdat,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdat
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdat;
  end

  assign rdat = mem[ridx];
endmodule

// File: rtl/eeprom_unlock.sv
module eeprom_unlock
  import eeprom_regctl_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       srst,
  input  logic       acc,
  input  logic       key_wr,
  input  logic [7:0] wdata,
  output logic       armed
);
  unlock_e st_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      st_q <= UL_IDLE;
    else if (srst)   st_q <= UL_IDLE;
    else if (acc) begin
      if (key_wr && wdata == KEY_FIRST)                        st_q <= UL_HALF;
      else if (key_wr && wdata == KEY_SECOND && st_q == UL_HALF) st_q <= UL_ARMED;
      else                                                     st_q <= UL_IDLE;
    end
  end

  assign armed = (st_q == UL_ARMED);

  // R5: arming only follows the second key byte
  assert_arm_after_key_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(armed) |-> $past(key_wr && wdata == KEY_SECOND));
endmodule

// File: rtl/eeprom_wtimer.sv
module eeprom_wtimer #(
  parameter int WR_CYCLES = 16,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic srst,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (srst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WR_CYCLES - 1);
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // R7: count stays inside the configured window
  assert_cnt_window_R7: assert property (@(posedge clk) disable iff (!por_n)
    busy_q |-> (cnt_q <= CW'(WR_CYCLES - 1)));
  // R7: expiry ends the cycle
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!por_n)
    done |=> !busy_q);
endmodule

// File: rtl/eeprom_regctl.sv
module eeprom_regctl
  import eeprom_regctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 128,
  parameter int WR_CYCLES = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       srst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q, wd_q, arr_rd, arr_wdat;
  logic [IDX_W-1:0]  wa_q, arr_widx;
  logic rd_go_q, wr_go_q, wen_q, err_q, irq_q, cfg_q, mem_q;
  logic armed, busy, done, arr_we;

  wire acc      = reg_wr || reg_rd;
  wire wr_data  = reg_wr && reg_sel == SEL_DATA;
  wire wr_addr  = reg_wr && reg_sel == SEL_ADDR;
  wire wr_ctrl  = reg_wr && reg_sel == SEL_CTRL;
  wire wr_key   = reg_wr && reg_sel == SEL_KEY;
  wire tgt_data = !reg_wdata[B_CFG] && !reg_wdata[B_MEM];
  wire wr_try   = wr_ctrl && reg_wdata[B_WR] && !busy;
  wire accept   = wr_try && armed && wen_q && tgt_data;
  wire bad_try  = wr_try && !accept;
  wire rd_ok    = wr_ctrl && reg_wdata[B_RD] && !busy && tgt_data;

  eeprom_unlock u_unlock (
    .clk(clk), .por_n(por_n), .srst(srst), .acc(acc),
    .key_wr(wr_key), .wdata(reg_wdata), .armed(armed)
  );

  eeprom_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .por_n(por_n), .srst(srst), .start(accept && !srst),
    .busy(busy), .done(done)
  );

  assign arr_we   = !srst && (accept || done);
  assign arr_widx = accept ? addr_q[IDX_W-1:0] : wa_q;
  assign arr_wdat = accept ? ERASED : wd_q;

  eeprom_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
    .clk(clk), .we(arr_we), .widx(arr_widx), .wdat(arr_wdat),
    .ridx(addr_q[IDX_W-1:0]), .rdat(arr_rd)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q <= '0; data_q <= '0; wa_q <= '0; wd_q <= '0;
      rd_go_q <= 1'b0; wr_go_q <= 1'b0; wen_q <= 1'b0; err_q <= 1'b0;
      irq_q <= 1'b0; cfg_q <= 1'b0; mem_q <= 1'b0;
    end else if (srst) begin
      addr_q <= '0; data_q <= '0;
      rd_go_q <= 1'b0; wr_go_q <= 1'b0; wen_q <= 1'b0;
      irq_q <= 1'b0; cfg_q <= 1'b0; mem_q <= 1'b0;
      err_q <= err_q || busy;
    end else begin
      if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
      if (rd_go_q)      data_q <= arr_rd;
      else if (wr_data) data_q <= reg_wdata;
      rd_go_q <= rd_ok;
      if (wr_ctrl) begin
        wen_q <= reg_wdata[B_WEN];
        cfg_q <= reg_wdata[B_CFG];
        mem_q <= reg_wdata[B_MEM];
      end
      if (accept)    wr_go_q <= 1'b1;
      else if (done) wr_go_q <= 1'b0;
      if (done)         irq_q <= 1'b1;
      else if (wr_ctrl) irq_q <= irq_q && reg_wdata[B_IRQ];
      if (bad_try)      err_q <= 1'b1;
      else if (wr_ctrl) err_q <= err_q && reg_wdata[B_ERR];
      if (accept) begin
        wa_q <= addr_q[IDX_W-1:0];
        wd_q <= data_q;
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_DATA: reg_rdata = data_q;
      SEL_ADDR: reg_rdata = 8'(addr_q);
      SEL_CTRL: reg_rdata = {mem_q, cfg_q, 1'b0, irq_q, err_q, wen_q, wr_go_q, rd_go_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq = irq_q;

  // R5: a write cycle only begins from an armed unlock
  assert_start_unlocked_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(armed));
  // R6: a write cycle only begins with write enable set
  assert_start_enabled_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(wen_q));
  // R7: software start bit mirrors the timer
  assert_wrgo_tracks_R7: assert property (@(posedge clk) disable iff (!por_n)
    wr_go_q == busy);
  // R3: read-start is a one-clock pulse
  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!por_n)
    rd_go_q |=> !rd_go_q);
  // R9: no read during a write
  assert_no_rd_busy_R9: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !rd_go_q);
  // R8: done flag rises only on timer expiry
  assert_irq_on_done_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(irq_q) |-> $past(done));
  // R10: aborting reset leaves the error flag set
  assert_abort_err_R10: assert property (@(posedge clk) disable iff (!por_n)
    (srst && busy) |=> err_q);
endmodule

// File: tb/eeprom_regctl_tb.sv
`timescale 1ns/1ps
module eeprom_regctl_tb;
  import eeprom_regctl_pkg::*;
  localparam int WRC = 16;

  logic clk = 1'b0, por_n = 1'b0, srst = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] shadow [128];
  bit known [128];
  logic [7:0] v;

  always #10 clk = ~clk;

  eeprom_regctl #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .por_n(por_n), .srst(srst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [6:0] idx_of(logic [7:0] a);
    return a[6:0];
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h exp %02h", req, got, exp);
    end
  endtask

  task automatic regwr(logic [1:0] s, logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic regrd(logic [1:0] s, output logic [7:0] d);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    regwr(SEL_KEY, KEY_FIRST);
    regwr(SEL_KEY, KEY_SECOND);
  endtask

  task automatic start_write(logic [7:0] a, logic [7:0] d);
    regwr(SEL_ADDR, a);
    regwr(SEL_DATA, d);
    unlock();
    regwr(SEL_CTRL, 8'h06);
  endtask

  task automatic do_read(logic [7:0] a, output logic [7:0] d);
    regwr(SEL_ADDR, a);
    regwr(SEL_CTRL, 8'h05);
    idle(1);
    peek(SEL_DATA, d);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] a, d, b;
    void'($urandom(32'd20240611));
    idle(2);
    por_n = 1'b1;
    idle(1);

    // R1 reset state
    peek(SEL_DATA, v); chk("R1 data", v, 8'h00);
    peek(SEL_ADDR, v); chk("R1 addr", v, 8'h00);
    peek(SEL_CTRL, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 register map, key reads zero
    regwr(SEL_KEY, 8'h5A); regrd(SEL_KEY, v); chk("R2 key", v, 8'h00);
    regwr(SEL_DATA, 8'h3C); regrd(SEL_DATA, v); chk("R2 data", v, 8'h3C);
    regwr(SEL_ADDR, 8'h81); regrd(SEL_ADDR, v); chk("R2 addr", v, 8'h81);

    // R7 write timing, software cannot clear start bit
    regwr(SEL_CTRL, 8'h04);
    start_write(8'h10, 8'hA5);
    idle(2);
    regwr(SEL_CTRL, 8'h04);
    peek(SEL_CTRL, v); chk("R7 hold", v & 8'h02, 8'h02);
    idle(WRC - 4);
    peek(SEL_CTRL, v); chk("R7 last busy", v & 8'h02, 8'h02);
    idle(1);
    peek(SEL_CTRL, v); chk("R7 cleared", v & 8'h02, 8'h00);
    chk("R8 irq set", {7'd0, irq}, 8'h01);
    shadow[8'h10] = 8'hA5; known[8'h10] = 1'b1;

    // R8 flag clear rule
    regwr(SEL_CTRL, 8'h14);
    peek(SEL_CTRL, v); chk("R8 keep", v & 8'h10, 8'h10);
    regwr(SEL_CTRL, 8'h04);
    chk("R8 clear", {7'd0, irq}, 8'h00);

    // R3 read pulse and alias
    regwr(SEL_ADDR, 8'h90);
    regwr(SEL_CTRL, 8'h05);
    peek(SEL_CTRL, v); chk("R3 rd pulse", v & 8'h01, 8'h01);
    idle(1);
    peek(SEL_CTRL, v); chk("R3 rd clear", v & 8'h01, 8'h00);
    peek(SEL_DATA, v); chk("R3 alias", v, 8'hA5);

    // R5 broken unlock (read in between)
    regwr(SEL_ADDR, 8'h10); regwr(SEL_DATA, 8'h77);
    regwr(SEL_KEY, KEY_FIRST); regrd(SEL_DATA, v); regwr(SEL_KEY, KEY_SECOND);
    regwr(SEL_CTRL, 8'h06);
    peek(SEL_CTRL, v); chk("R5 broken", v, 8'h0C);
    // R5 no unlock at all
    regwr(SEL_CTRL, 8'h06);
    peek(SEL_CTRL, v); chk("R5 none", v, 8'h0C);
    idle(WRC + 2);
    // R12 error clear rule
    regwr(SEL_CTRL, 8'h0C);
    peek(SEL_CTRL, v); chk("R12 keep", v, 8'h0C);
    regwr(SEL_CTRL, 8'h04);
    peek(SEL_CTRL, v); chk("R12 clear", v, 8'h04);
    do_read(8'h10, v); chk("R5 mem intact", v, 8'hA5);

    // R6 write enable off
    regwr(SEL_CTRL, 8'h00);
    regwr(SEL_DATA, 8'h33);
    unlock();
    regwr(SEL_CTRL, 8'h02);
    peek(SEL_CTRL, v); chk("R6 rejected", v, 8'h08);
    idle(WRC + 2);
    regwr(SEL_CTRL, 8'h04);
    do_read(8'h10, v); chk("R6 mem intact", v, 8'hA5);

    // R11 program target write, R4 read-start rejects
    regwr(SEL_CTRL, 8'h84);
    unlock();
    regwr(SEL_CTRL, 8'h86);
    peek(SEL_CTRL, v); chk("R11 rejected", v, 8'h8C);
    regwr(SEL_CTRL, 8'h85);
    peek(SEL_CTRL, v); chk("R4 program", v & 8'h01, 8'h00);
    regwr(SEL_CTRL, 8'h45);
    peek(SEL_CTRL, v); chk("R4 config", v, 8'h44);
    idle(1);
    peek(SEL_DATA, v); chk("R4 data kept", v, 8'hA5);
    regwr(SEL_CTRL, 8'h04);
    do_read(8'h10, v); chk("R11 mem intact", v, 8'hA5);

    // R9 requests ignored during a write
    start_write(8'h20, 8'h5C);
    regwr(SEL_CTRL, 8'h05);
    idle(1);
    peek(SEL_CTRL, v); chk("R9 no read", v & 8'h01, 8'h00);
    peek(SEL_DATA, v); chk("R9 data kept", v, 8'h5C);
    unlock();
    regwr(SEL_CTRL, 8'h06);
    peek(SEL_CTRL, v); chk("R9 no err", v & 8'h0A, 8'h02);
    idle(WRC);
    peek(SEL_CTRL, v); chk("R9 no restart", v & 8'h02, 8'h00);
    shadow[8'h20] = 8'h5C; known[8'h20] = 1'b1;
    do_read(8'hA0, v); chk("R3 alias high", v, 8'h5C);

    // R10 abort by soft reset
    start_write(8'h30, 8'hE7);
    idle(3);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    peek(SEL_CTRL, v); chk("R10 ctrl", v, 8'h08);
    chk("R10 irq", {7'd0, irq}, 8'h00);
    idle(WRC + 2);
    peek(SEL_CTRL, v); chk("R10 no finish", v, 8'h08);
    regwr(SEL_CTRL, 8'h04);
    do_read(8'h30, v); chk("R10 erased", v, ERASED);
    shadow[8'h30] = ERASED; known[8'h30] = 1'b1;

    // Random writes and readbacks, with rejected attempts mixed in
    for (int i = 0; i < 24; i++) begin
      a = 8'($urandom);
      d = 8'($urandom);
      start_write(a, d);
      idle(WRC);
      shadow[idx_of(a)] = d; known[idx_of(a)] = 1'b1;
      chk("R8 random irq", {7'd0, irq}, 8'h01);
      if (i % 3 == 0) begin
        regwr(SEL_DATA, ~d);
        regwr(SEL_KEY, KEY_FIRST); regwr(SEL_DATA, ~d); regwr(SEL_KEY, KEY_SECOND);
        regwr(SEL_CTRL, 8'h06);
        peek(SEL_CTRL, v); chk("R5 random reject", v & 8'h0A, 8'h08);
        idle(WRC + 1);
        regwr(SEL_CTRL, 8'h04);
      end
      b = 8'($urandom);
      while (!known[idx_of(b)]) b = 8'($urandom);
      do_read(b, v); chk("R7 random readback", v, shadow[idx_of(b)]);
      do_read(a ^ 8'h80, v); chk("R3 random alias", v, shadow[idx_of(a)]);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule